// File: doc/BRIEF.md
# Grounded-Neutral Oscillation Detector

This block decides whether a grounded-neutral fault is present. A normally silent sense oscillator starts to ring when the neutral is grounded on the load side. An analog comparator turns that ringing into a digital level. The block qualifies each high phase of that level, and confirms that qualified pulses keep arriving for a persistence window. It then deliberately switches the oscillator amplifier off for a quiet interval and switches it back on. The fault is declared only if the oscillation starts again after the amplifier returns. A ring that was real restarts by itself. A burst of noise does not.

A declared fault raises a latched trip request that drives the breaker's solid-state switch. A build parameter selects how many disable/re-enable rounds must succeed before the trip is requested: one or two. A function-enable input, pulled high on the board, lets the whole detector be switched off. All durations are parameters counted in clock cycles. Their defaults are scaled down so that a simulation finishes quickly.

Top module: `gn_osc_detect`

## Requirements
- R1: A comparator high phase produces a qualified pulse only if it lasts more than QUAL_CYC consecutive clock cycles (default 8). A high phase of exactly QUAL_CYC cycles or fewer is never counted.
- R2: After the first qualified pulse, the amplifier is switched off only once PERSIST_CYC cycles (default 200) have elapsed. During that time no gap between qualified pulses may exceed GAP_CYC+1 cycles (default 60). A longer gap returns the detector to idle.
- R3: The amplifier-enable output `amp_en` stays low for exactly QUIET_CYC consecutive cycles (default 300) per round. During that time the comparator is ignored.
- R4: After `amp_en` returns high, a qualified pulse within RECHK_CYC cycles (default 120) completes the round. If no qualified pulse arrives in that window, the detector returns to idle without tripping.
- R5: With ROUNDS=2, the trip is requested only after two consecutive rounds succeed, each with its own persistence and quiet intervals. With ROUNDS=1, a single round is enough.
- R6: The trip request `gn_trip` (1 = trip) stays high once raised, even after the oscillation stops. It clears only when `gn_en` goes low or on reset.
- R7: While `gn_en` is low, the detector is held idle. In that case `gn_trip` is 0 and `amp_en` is 1 one cycle later, and comparator activity has no effect.
- R8: `amp_en` is 1 in every state except the quiet interval. After reset, `amp_en` is 1 and `gn_trip` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| gn_en | input | 1 | Function enable; 0 holds the detector idle and clears the trip |
| cmp_in | input | 1 | Asynchronous comparator level from the sense node (1 = above threshold) |
| amp_en | output | 1 | Sense amplifier enable; 0 only during the quiet interval |
| gn_trip | output | 1 | Latched grounded-neutral trip request |

## Verification
Some properties are checked by assertions on every cycle. The length of each quiet interval is checked against QUIET_CYC. The trip latch must hold while the function is enabled. A low enable must force the idle outputs one cycle later. The trip may never be raised while the amplifier is off. The scenarios in the bench are what show the other behaviours. These are the qualification boundary at QUAL_CYC and QUAL_CYC+1 cycles, idle after a pulse gap that is too long, the abandoned round when the ring does not come back, and the longer path to a trip in the two-round build. They are shown by driving a modelled oscillator that rings only while the fault is present and the amplifier is on.

// File: rtl/gn_pkg.sv
package gn_pkg;
  typedef enum logic [2:0] {
    GN_IDLE  = 3'd0,
    GN_WATCH = 3'd1,
    GN_QUIET = 3'd2,
    GN_RECHK = 3'd3,
    GN_TRIP  = 3'd4
  } gn_state_e;
endpackage

// File: rtl/gn_sync.sv
module gn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain[STAGES-2:0], d_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= chain_nxt;
  end

  assign q_out = chain[STAGES-1];
endmodule

// File: rtl/gn_pulse_qual.sv
module gn_pulse_qual #(
  parameter int QUAL_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic lvl,
  output logic q_pulse
);
  localparam int RW = $clog2(QUAL_CYC + 2);
  localparam logic [RW-1:0] RUN_HIT = RW'(QUAL_CYC);
  localparam logic [RW-1:0] RUN_SAT = RW'(QUAL_CYC + 1);

  logic [RW-1:0] run_q, run_nxt;
  logic          pulse_nxt;

  // count consecutive high samples; saturate so one pulse per high phase
  always_comb begin
    if (!en || !lvl)            run_nxt = '0;
    else if (run_q != RUN_SAT)  run_nxt = run_q + 1'b1;
    else                        run_nxt = run_q;
    pulse_nxt = en && lvl && (run_q == RUN_HIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      q_pulse <= 1'b0;
    end else begin
      run_q   <= run_nxt;
      q_pulse <= pulse_nxt;
    end
  end
endmodule

// File: rtl/gn_seq.sv
module gn_seq
  import gn_pkg::*;
#(
  parameter int PERSIST_CYC = 200,
  parameter int GAP_CYC     = 60,
  parameter int QUIET_CYC   = 300,
  parameter int RECHK_CYC   = 120,
  parameter int ROUNDS      = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic q_pulse,
  output logic amp_en,
  output logic trip
);
  localparam int MAX_A = (PERSIST_CYC > QUIET_CYC) ? PERSIST_CYC : QUIET_CYC;
  localparam int MAX_T = (MAX_A > RECHK_CYC) ? MAX_A : RECHK_CYC;
  localparam int TW    = $clog2(MAX_T + 1);
  localparam int GW    = $clog2(GAP_CYC + 2);
  localparam int NW    = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;

  localparam logic [TW-1:0] T_PERS  = TW'(PERSIST_CYC - 1);
  localparam logic [TW-1:0] T_QUIET = TW'(QUIET_CYC - 1);
  localparam logic [TW-1:0] T_RECHK = TW'(RECHK_CYC - 1);
  localparam logic [GW-1:0] G_LIM   = GW'(GAP_CYC);
  localparam logic [NW-1:0] N_LAST  = NW'(ROUNDS - 1);

  gn_state_e     st_q, st_nxt;
  logic [TW-1:0] tmr_q, tmr_nxt;
  logic [GW-1:0] gap_q, gap_nxt;
  logic [NW-1:0] rnd_q, rnd_nxt;
  logic          tmr_ce, gap_ce, rnd_ce;

  always_comb begin
    st_nxt  = st_q;
    tmr_nxt = tmr_q + 1'b1;
    gap_nxt = q_pulse ? '0 : gap_q + 1'b1;
    rnd_nxt = rnd_q;
    unique case (st_q)
      GN_IDLE: begin
        tmr_nxt = '0;
        gap_nxt = '0;
        rnd_nxt = '0;
        if (q_pulse) st_nxt = GN_WATCH;
      end
      GN_WATCH: begin
        if (!q_pulse && gap_q == G_LIM) begin
          st_nxt = GN_IDLE;
        end else if (tmr_q == T_PERS) begin
          st_nxt  = GN_QUIET;
          tmr_nxt = '0;
        end
      end
      GN_QUIET: begin
        if (tmr_q == T_QUIET) begin
          st_nxt  = GN_RECHK;
          tmr_nxt = '0;
        end
      end
      GN_RECHK: begin
        if (q_pulse) begin
          if (rnd_q == N_LAST) begin
            st_nxt = GN_TRIP;
          end else begin
            st_nxt  = GN_WATCH;
            rnd_nxt = rnd_q + 1'b1;
            tmr_nxt = '0;
            gap_nxt = '0;
          end
        end else if (tmr_q == T_RECHK) begin
          st_nxt = GN_IDLE;
        end
      end
      GN_TRIP: begin
        tmr_nxt = tmr_q;
      end
      default: st_nxt = GN_IDLE;
    endcase
    if (!en) begin
      st_nxt  = GN_IDLE;
      tmr_nxt = '0;
      gap_nxt = '0;
      rnd_nxt = '0;
    end
  end

  assign tmr_ce = (st_q != GN_TRIP) || !en;
  assign gap_ce = (st_q == GN_WATCH) || (st_q == GN_IDLE) || (st_q == GN_RECHK) || !en;
  assign rnd_ce = (st_q == GN_IDLE) || (st_q == GN_RECHK) || !en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= GN_IDLE;
      tmr_q <= '0;
      gap_q <= '0;
      rnd_q <= '0;
    end else begin
      st_q <= st_nxt;
      if (tmr_ce) tmr_q <= tmr_nxt;
      if (gap_ce) gap_q <= gap_nxt;
      if (rnd_ce) rnd_q <= rnd_nxt;
    end
  end

  assign amp_en = (st_q != GN_QUIET);
  assign trip   = (st_q == GN_TRIP);
endmodule

// File: rtl/gn_osc_detect.sv
module gn_osc_detect #(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYC    = 8,
  parameter int PERSIST_CYC = 200,
  parameter int GAP_CYC     = 60,
  parameter int QUIET_CYC   = 300,
  parameter int RECHK_CYC   = 120,
  parameter int ROUNDS      = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gn_en,
  input  logic cmp_in,
  output logic amp_en,
  output logic gn_trip
);
  logic [1:0] rst_pipe;
  logic       rst_n_s;
  logic       cmp_s;
  logic       q_pulse;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  gn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d_in  (cmp_in),
    .q_out (cmp_s)
  );

  gn_pulse_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .en      (gn_en),
    .lvl     (cmp_s),
    .q_pulse (q_pulse)
  );

  gn_seq #(
    .PERSIST_CYC (PERSIST_CYC),
    .GAP_CYC     (GAP_CYC),
    .QUIET_CYC   (QUIET_CYC),
    .RECHK_CYC   (RECHK_CYC),
    .ROUNDS      (ROUNDS)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .en      (gn_en),
    .q_pulse (q_pulse),
    .amp_en  (amp_en),
    .trip    (gn_trip)
  );
endmodule

// File: rtl/gn_osc_checker.sv
module gn_osc_checker #(
  parameter int QUIET_CYC = 300
) (
  input logic clk,
  input logic rst_n,
  input logic gn_en,
  input logic amp_en,
  input logic gn_trip
);
  localparam int LW = $clog2(QUIET_CYC + 2);
  logic [LW-1:0] low_cnt;

  // cycles amp_en has been low in the current stretch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          low_cnt <= '0;
    else if (amp_en)                     low_cnt <= '0;
    else if (low_cnt != LW'(QUIET_CYC + 1)) low_cnt <= low_cnt + 1'b1;
  end

  assert_quiet_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (amp_en && !$past(amp_en) && $past(gn_en)) |-> (low_cnt == LW'(QUIET_CYC)));

  assert_quiet_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt <= LW'(QUIET_CYC));

  assert_disable_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !gn_en |=> (amp_en && !gn_trip));

  assert_trip_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gn_trip && gn_en) |=> gn_trip);

  assert_trip_amp_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gn_trip |-> amp_en);

  assert_trip_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gn_trip) |-> ($past(amp_en) && $past(gn_en)));
endmodule

bind gn_osc_detect gn_osc_checker #(.QUIET_CYC(QUIET_CYC)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .gn_en   (gn_en),
  .amp_en  (amp_en),
  .gn_trip (gn_trip)
);

// File: tb/tb_gn_osc_detect.sv
module tb_gn_osc_detect;
  localparam int PERSIST = 200;
  localparam int QUIET   = 300;
  localparam int RECHK   = 120;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, gn_en, cmp_a, cmp_b;
  logic amp_a, amp_b, trip_a, trip_b;

  gn_osc_detect #(.ROUNDS(1)) dut (
    .clk(clk), .rst_n(rst_n), .gn_en(gn_en), .cmp_in(cmp_a),
    .amp_en(amp_a), .gn_trip(trip_a));

  gn_osc_detect #(.ROUNDS(2)) dut2 (
    .clk(clk), .rst_n(rst_n), .gn_en(gn_en), .cmp_in(cmp_b),
    .amp_en(amp_b), .gn_trip(trip_b));

  // oscillator model: rings only while the fault is present and the amp is on
  int  hi_len, per_len, ph;
  bit  osc_on, restart;
  int  n_chk = 0, n_bad = 0;

  initial begin
    ph = 0; hi_len = 20; per_len = 40; osc_on = 0; restart = 0;
    cmp_a = 0; cmp_b = 0;
    forever begin
      @(negedge clk);
      if (restart) ph = 0;
      else         ph = (ph + 1 >= per_len) ? 0 : ph + 1;
      cmp_a = osc_on && amp_a && (ph < hi_len);
      cmp_b = osc_on && amp_b && (ph < hi_len);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_osc(input int hi, input int per);
    hi_len = hi; per_len = per; restart = 1;
    cyc(1);
    restart = 0; osc_on = 1;
  endtask

  task automatic clear_en;
    osc_on = 0; gn_en = 0;
    cyc(4);
    gn_en = 1;
    cyc(4);
  endtask

  // hi, period, duration, expected trip (1 round), expected trip (2 rounds)
  localparam int NV = 7;
  localparam int VEC [NV][5] = '{
    '{20,  40, 1400, 1, 1},
    '{ 6,  40, 1400, 0, 0},
    '{ 8,  40, 1400, 0, 0},
    '{ 9,  40, 1400, 1, 1},
    '{20, 100, 1400, 0, 0},
    '{20,  40,  800, 1, 0},
    '{30,  50, 1400, 1, 1}
  };

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
  end

  initial begin
    int t, q, bad_seen;
    rst_n = 0; gn_en = 1;
    cyc(5);
    // R8: reset state
    check(trip_a == 0 && trip_b == 0, "R8 reset trip", trip_a, 0);
    check(amp_a == 1 && amp_b == 1, "R8 reset amp_en", amp_a, 1);
    rst_n = 1;
    cyc(5);
    check(amp_a == 1 && trip_a == 0, "R8 idle after reset", amp_a, 1);

    // table: R1 qualification, R2 gap, R5 rounds
    for (int i = 0; i < NV; i++) begin
      start_osc(VEC[i][0], VEC[i][1]);
      cyc(VEC[i][2]);
      check(trip_a == VEC[i][3][0], $sformatf("R1/R2 row %0d one-round trip", i),
            trip_a, VEC[i][3]);
      check(trip_b == VEC[i][4][0], $sformatf("R5 row %0d two-round trip", i),
            trip_b, VEC[i][4]);
      clear_en();
      check(trip_a == 0 && amp_a == 1, $sformatf("R7 row %0d cleared", i), trip_a, 0);
    end

    // R2/R3: persistence before shutoff, exact quiet length
    start_osc(20, 40);
    t = 0;
    while (amp_a && t < 2000) begin t++; cyc(1); end
    check(t >= PERSIST && t <= PERSIST + 40, "R2 persistence before shutoff", t, PERSIST);
    q = 0;
    while (!amp_a && q < 2000) begin q++; cyc(1); end
    check(q == QUIET, "R3 quiet interval length", q, QUIET);
    check(trip_a == 0, "R4 no trip before recheck", trip_a, 0);
    t = 0;
    while (!trip_a && t < 1000) begin t++; cyc(1); end
    check(t <= RECHK, "R4 trip after ring returns", t, RECHK);
    // R6: latched after oscillation stops
    osc_on = 0;
    cyc(500);
    check(trip_a == 1, "R6 trip latched", trip_a, 1);
    clear_en();

    // R4: ring does not return after the quiet interval
    start_osc(20, 40);
    t = 0;
    while (amp_a && t < 2000) begin t++; cyc(1); end
    osc_on = 0;
    cyc(800);
    check(trip_a == 0, "R4 no return no trip", trip_a, 0);
    check(amp_a == 1, "R8 amp on after abandoned round", amp_a, 1);
    clear_en();

    // R4/R5: trip latency for one and two rounds
    start_osc(20, 40);
    t = 0;
    while (!trip_b && t < 3000) begin
      if (trip_a && q >= 0) begin q = -1; check(t <= 600, "R4 one-round latency", t, 600); end
      t++; cyc(1);
    end
    check(t > 900 && t <= 1200, "R5 two-round latency", t, 1100);

    // R7: disable clears trip and blocks the function
    gn_en = 0;
    cyc(1);
    check(trip_a == 0 && trip_b == 0, "R7 trip cleared by enable low", trip_a, 0);
    bad_seen = 0;
    for (int k = 0; k < 1500; k++) begin
      if (!amp_a || !amp_b || trip_a || trip_b) bad_seen = 1;
      cyc(1);
    end
    check(bad_seen == 0, "R7 comparator ignored while disabled", bad_seen, 0);
    gn_en = 1;

    // R6: reset clears a latched trip
    start_osc(20, 40);
    cyc(800);
    check(trip_a == 1, "R6 trip before reset", trip_a, 1);
    rst_n = 0;
    cyc(1);
    check(trip_a == 0 && amp_a == 1, "R6 reset clears trip", trip_a, 0);
    osc_on = 0;
    cyc(3);
    rst_n = 1;
    cyc(5);
    report();
  end
endmodule